// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block decides when a processor core may run and when it must sit in a low-power standby state with its clock held off. It works on a reference clock that keeps running through standby. When the core raises a sleep request while the standby-enable control bit is set, the block enters software standby and drops the core clock enable. A sleep request with the enable bit clear is ignored.

Software standby ends on a qualified edge of one of two wake pins. The first is the non-maskable interrupt pin, whose polarity comes from a single select bit. The second is an external interrupt pin with a two-bit sense setting. The wake edge starts an oscillation-settling wait of a programmable number of reference cycles. Only after that wait does the core clock come back. In the first run cycle the block emits a one-cycle pulse that names the pin which caused the wake-up. An active-low hardware standby pin overrides everything: while it is low the block stays in hardware standby, and after release it goes through the same settling wait that follows reset.

All three pins pass through a two-flop synchronizer. An edge is seen when the synchronized value differs from its registered previous value.

Top module: `stby_wake_ctrl`

## Requirements
- R1: During and just after reset, clk_en_o is 0, stby_o is 1 and both wake pulses are 0. With hstby_ni held high, clk_en_o rises at the (SETTLE+4)th rising clock edge after reset is released, where SETTLE is the value on settle_cnt_i.
- R2: In run, a sleep_req_i sampled high with stby_en_i = 1 makes clk_en_o 0 and stby_o 1 after the next clock edge.
- R3: In run, a sleep_req_i with stby_en_i = 0 has no effect: clk_en_o stays 1.
- R4: nmi_pol_i = 0 selects a falling edge on nmi_i as the wake edge and nmi_pol_i = 1 selects a rising edge. An edge of the other direction does not end standby.
- R5: irq_sense_i encodes 2'b01 = falling, 2'b10 = rising and 2'b11 = both. With 2'b01 or 2'b11 only a falling edge on irq_i ends standby. With 2'b10 only a rising edge does.
- R6: irq_sense_i = 2'b00 (level sense) never ends standby, whatever irq_i does.
- R7: After a wake edge is driven on a pin, clk_en_o stays 0 through the (SETTLE+3)th rising edge and becomes 1 at the (SETTLE+4)th. SETTLE = 0 is allowed.
- R8: In the first run cycle after a wake-up, exactly one of nmi_wake_o or irq_wake_o is high, for exactly one cycle, naming the source. If both pins present a wake edge in the same cycle, nmi_wake_o is the one raised.
- R9: When hstby_ni goes low, the block is in hardware standby (clk_en_o 0, stby_o 1) from the third rising edge on, from any state, and it stays there while the pin is low.
- R10: When hstby_ni is released, clk_en_o returns at the (SETTLE+4)th rising edge, and no wake pulse is issued.
- R11: Pin edges seen in run, in hardware standby or during the settling wait raise no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Sleep request from the core |
| stby_en_i | input | 1 | Standby-enable control bit |
| nmi_pol_i | input | 1 | NMI wake polarity: 0 falling, 1 rising |
| irq_sense_i | input | 2 | IRQ sense: 00 level, 01 falling, 10 rising, 11 both |
| settle_cnt_i | input | CNT_W | Settling wait length in reference cycles |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| irq_i | input | 1 | External interrupt pin |
| hstby_ni | input | 1 | Hardware standby pin, active low |
| clk_en_o | output | 1 | Core clock enable |
| stby_o | output | 1 | High whenever the core is not running |
| nmi_wake_o | output | 1 | One-cycle pulse: wake-up caused by NMI |
| irq_wake_o | output | 1 | One-cycle pulse: wake-up caused by IRQ |

## Verification
The wake path is tried with each NMI polarity and each IRQ sense code. Each standby episode first applies the edge of the wrong direction and then the right one, which separates a correct polarity decode from a detector that wakes on any toggle. Level sense is held low for many cycles, and one case drives simultaneous edges on both pins; these cover wake-up on a disallowed setting and a wrong priority. Settling lengths of 0, 5 and 20 cycles fix the clock-return cycle exactly. Hardware standby is entered from run, from software standby and from the middle of a settling wait, which shows that the pin overrides every state and that its release never produces a wake pulse.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int unsigned CNT_W = 16;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SW     = 2'd1,
        ST_SETTLE = 2'd2,
        ST_HW     = 2'd3
    } stby_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_IRQ  = 2'd2
    } wake_src_e;

    localparam logic [1:0] SENSE_LEVEL = 2'b00;
    localparam logic [1:0] SENSE_FALL  = 2'b01;
    localparam logic [1:0] SENSE_RISE  = 2'b10;
    localparam logic [1:0] SENSE_BOTH  = 2'b11;

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
    parameter int unsigned W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = pin_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sy_q <= '{s1: {W{RST_VAL}}, s2: {W{RST_VAL}}};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign lvl_o = sy_q.s2;

endmodule

// File: rtl/stby_edge_det.sv
module stby_edge_det #(
    parameter int unsigned W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] lvl;
    logic [W-1:0] prev_d, prev_q;

    stby_sync #(.W(W), .RST_VAL(1'b0)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (pin_i),
        .lvl_o (lvl)
    );

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise_o[g] = lvl[g] & ~prev_q[g];
        assign fall_o[g] = ~lvl[g] & prev_q[g];
    end

endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
    parameter int unsigned CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_o = 1'b0;
        if (!run_i) begin
            cnt_d = '0;
        end else begin
            done_o = (cnt_q == limit_i);
            if (cnt_q != {CW{1'b1}}) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned CNT_W = stby_pkg::CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sleep_req_i,
    input  logic             stby_en_i,
    input  logic             nmi_pol_i,
    input  logic [1:0]       irq_sense_i,
    input  logic [CNT_W-1:0] settle_cnt_i,
    input  logic             nmi_i,
    input  logic             irq_i,
    input  logic             hstby_ni,
    output logic             clk_en_o,
    output logic             stby_o,
    output logic             nmi_wake_o,
    output logic             irq_wake_o
);

    localparam int unsigned NWAKE   = 2;
    localparam int unsigned IDX_NMI = 0;
    localparam int unsigned IDX_IRQ = 1;

    typedef struct packed {
        stby_state_e state;
        wake_src_e   src;
        logic        clk_en;
        logic        stby;
        logic        nmi_pls;
        logic        irq_pls;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        state:   ST_HW,
        src:     SRC_NONE,
        clk_en:  1'b0,
        stby:    1'b1,
        nmi_pls: 1'b0,
        irq_pls: 1'b0
    };

    ctrl_t ctl_d, ctl_q;

    logic [NWAKE-1:0] rise, fall;
    logic             hw_ok;
    logic             settle_run;
    logic             settle_done;
    logic             nmi_hit;
    logic             irq_hit;

    stby_edge_det #(.W(NWAKE)) u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i ({irq_i, nmi_i}),
        .rise_o(rise),
        .fall_o(fall)
    );

    stby_sync #(.W(1), .RST_VAL(1'b0)) u_hw_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (hstby_ni),
        .lvl_o (hw_ok)
    );

    assign settle_run = (ctl_q.state == ST_SETTLE);

    stby_settle_cnt #(.CW(CNT_W)) u_settle (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (settle_run),
        .limit_i(settle_cnt_i),
        .done_o (settle_done)
    );

    // wake qualification: polarity for NMI, sense code for IRQ
    always_comb begin
        nmi_hit = nmi_pol_i ? rise[IDX_NMI] : fall[IDX_NMI];
        unique case (irq_sense_i)
            SENSE_FALL:  irq_hit = fall[IDX_IRQ];
            SENSE_BOTH:  irq_hit = fall[IDX_IRQ];
            SENSE_RISE:  irq_hit = rise[IDX_IRQ];
            default:     irq_hit = 1'b0;
        endcase
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.nmi_pls = 1'b0;
        ctl_d.irq_pls = 1'b0;

        if (!hw_ok) begin
            ctl_d.state = ST_HW;
            ctl_d.src   = SRC_NONE;
        end else begin
            unique case (ctl_q.state)
                ST_RUN: begin
                    if (sleep_req_i && stby_en_i) begin
                        ctl_d.state = ST_SW;
                        ctl_d.src   = SRC_NONE;
                    end
                end
                ST_SW: begin
                    if (nmi_hit) begin
                        ctl_d.state = ST_SETTLE;
                        ctl_d.src   = SRC_NMI;
                    end else if (irq_hit) begin
                        ctl_d.state = ST_SETTLE;
                        ctl_d.src   = SRC_IRQ;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        ctl_d.state   = ST_RUN;
                        ctl_d.nmi_pls = (ctl_q.src == SRC_NMI);
                        ctl_d.irq_pls = (ctl_q.src == SRC_IRQ);
                        ctl_d.src     = SRC_NONE;
                    end
                end
                default: begin
                    ctl_d.state = ST_SETTLE;
                    ctl_d.src   = SRC_NONE;
                end
            endcase
        end

        ctl_d.clk_en = (ctl_d.state == ST_RUN);
        ctl_d.stby   = (ctl_d.state != ST_RUN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= CTRL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign clk_en_o   = ctl_q.clk_en;
    assign stby_o     = ctl_q.stby;
    assign nmi_wake_o = ctl_q.nmi_pls;
    assign irq_wake_o = ctl_q.irq_pls;

endmodule

// File: rtl/stby_wake_ctrl_chk.sv
module stby_wake_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sleep_req_i,
    input logic stby_en_i,
    input logic hw_ok_i,
    input logic clk_en_o,
    input logic stby_o,
    input logic nmi_wake_o,
    input logic irq_wake_o
);

    p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_en_o && sleep_req_i && stby_en_i && hw_ok_i) |=> (!clk_en_o && stby_o));

    p_no_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_en_o && sleep_req_i && !stby_en_i && hw_ok_i) |=> clk_en_o);

    p_one_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({nmi_wake_o, irq_wake_o}));

    p_pulse_short_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_wake_o || irq_wake_o) |=> (!nmi_wake_o && !irq_wake_o));

    p_pulse_at_resume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_wake_o || irq_wake_o) |-> (clk_en_o && !$past(clk_en_o)));

    p_hw_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hw_ok_i |=> (!clk_en_o && stby_o && !nmi_wake_o && !irq_wake_o));

    p_run_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_en_o |-> !stby_o);

endmodule

bind stby_wake_ctrl stby_wake_ctrl_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req_i),
    .stby_en_i  (stby_en_i),
    .hw_ok_i    (hw_ok),
    .clk_en_o   (clk_en_o),
    .stby_o     (stby_o),
    .nmi_wake_o (nmi_wake_o),
    .irq_wake_o (irq_wake_o)
);

// File: tb/stby_wake_ctrl_tb_top.sv
module stby_wake_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SRC_NMI = 1;
    localparam int SRC_IRQ = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_req = 1'b0;
    logic        stby_en = 1'b0;
    logic        nmi_pol = 1'b1;
    logic [1:0]  irq_sense = 2'b01;
    logic [15:0] settle = 16'd5;
    logic        nmi = 1'b0;
    logic        irq = 1'b1;
    logic        hstby_n = 1'b1;
    logic        clk_en, stby, nmi_wake, irq_wake;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    stby_wake_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sleep_req_i (sleep_req),
        .stby_en_i   (stby_en),
        .nmi_pol_i   (nmi_pol),
        .irq_sense_i (irq_sense),
        .settle_cnt_i(settle),
        .nmi_i       (nmi),
        .irq_i       (irq),
        .hstby_ni    (hstby_n),
        .clk_en_o    (clk_en),
        .stby_o      (stby),
        .nmi_wake_o  (nmi_wake),
        .irq_wake_o  (irq_wake)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected source per observed wake pulse (R8, R11)
    always @(negedge clk) begin
        if (rst_n && (nmi_wake || irq_wake)) begin
            int got;
            got = nmi_wake ? SRC_NMI : SRC_IRQ;
            if (nmi_wake && irq_wake) got = 3;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", got, 0);
            end else begin
                int want;
                want = exp_q.pop_front();
                chk(got == want, "R8", got, want);
            end
        end
    end

    task automatic enter_sw();
        stby_en   = 1'b1;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        chk(clk_en == 1'b0, "R2", clk_en, 0);
        chk(stby == 1'b1, "R2", stby, 1);
        step(3);
    endtask

    task automatic expect_resume(input int n, input string req);
        step(n + 3);
        chk(clk_en == 1'b0, req, clk_en, 0);
        step(1);
        chk(clk_en == 1'b1, req, clk_en, 1);
        chk(stby == 1'b0, req, stby, 0);
        step(3);
    endtask

    task automatic still_asleep(input int n, input string req);
        step(n);
        chk(clk_en == 1'b0, req, clk_en, 0);
        chk(stby == 1'b1, req, stby, 1);
    endtask

    initial begin
        step(3);
        chk(clk_en == 1'b0, "R1", clk_en, 0);
        chk(stby == 1'b1, "R1", stby, 1);
        chk({nmi_wake, irq_wake} == 2'b00, "R1", {nmi_wake, irq_wake}, 0);
        rst_n = 1'b1;
        expect_resume(5, "R1");

        // R3: sleep request without enable is ignored
        stby_en = 1'b0; sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        chk(clk_en == 1'b1, "R3", clk_en, 1);
        step(3);
        chk(clk_en == 1'b1, "R3", clk_en, 1);

        // R11: NMI edges in run raise no pulse
        nmi = 1'b1; step(5); nmi = 1'b0; step(5);

        // R4: falling polarity, rising edge must not wake
        nmi_pol = 1'b0;
        enter_sw();
        nmi = 1'b1;
        still_asleep(8, "R4");
        nmi = 1'b0; exp_q.push_back(SRC_NMI);
        expect_resume(5, "R4");

        // R4: rising polarity, falling edge must not wake
        nmi_pol = 1'b1; nmi = 1'b1; step(4);
        enter_sw();
        nmi = 1'b0;
        still_asleep(8, "R4");
        nmi = 1'b1; exp_q.push_back(SRC_NMI);
        expect_resume(5, "R7");
        nmi = 1'b0; step(4);

        // R5: sense falling
        irq_sense = 2'b01; irq = 1'b0; step(4);
        enter_sw();
        irq = 1'b1;
        still_asleep(8, "R5");
        irq = 1'b0; exp_q.push_back(SRC_IRQ);
        expect_resume(5, "R5");

        // R5: sense both, rising ignored, falling wakes
        irq_sense = 2'b11;
        enter_sw();
        irq = 1'b1;
        still_asleep(8, "R5");
        irq = 1'b0; exp_q.push_back(SRC_IRQ);
        expect_resume(5, "R5");

        // R5: sense rising, falling ignored
        irq_sense = 2'b10; irq = 1'b1; step(4);
        enter_sw();
        irq = 1'b0;
        still_asleep(8, "R5");
        irq = 1'b1; exp_q.push_back(SRC_IRQ);
        expect_resume(5, "R5");

        // R6: level sense never wakes
        irq_sense = 2'b00;
        enter_sw();
        irq = 1'b0;
        still_asleep(25, "R6");
        irq = 1'b1;
        still_asleep(8, "R6");
        nmi = 1'b1; exp_q.push_back(SRC_NMI);
        expect_resume(5, "R6");
        nmi = 1'b0; step(4);

        // R8: simultaneous edges, NMI wins
        irq_sense = 2'b01;
        enter_sw();
        nmi = 1'b1; irq = 1'b0; exp_q.push_back(SRC_NMI);
        expect_resume(5, "R8");
        nmi = 1'b0; irq = 1'b1; step(4);

        // R7: zero and long settling waits
        settle = 16'd0;
        enter_sw();
        nmi = 1'b1; exp_q.push_back(SRC_NMI);
        expect_resume(0, "R7");
        nmi = 1'b0; step(4);
        settle = 16'd20;
        enter_sw();
        irq = 1'b0; exp_q.push_back(SRC_IRQ);
        expect_resume(20, "R7");
        irq = 1'b1; step(4);
        settle = 16'd5;

        // R9/R10: hardware standby from run
        hstby_n = 1'b0;
        step(2);
        chk(clk_en == 1'b1, "R9", clk_en, 1);
        step(1);
        chk(clk_en == 1'b0, "R9", clk_en, 0);
        still_asleep(10, "R9");
        hstby_n = 1'b1;
        expect_resume(5, "R10");

        // R9/R11: hardware standby from software standby, NMI edge ignored
        enter_sw();
        hstby_n = 1'b0;
        still_asleep(3, "R9");
        nmi = 1'b1; step(5); nmi = 1'b0;
        still_asleep(6, "R11");
        hstby_n = 1'b1;
        expect_resume(5, "R10");

        // R9/R10: hardware standby during settling wait, no pulse
        settle = 16'd20;
        enter_sw();
        nmi = 1'b1;
        step(8);
        hstby_n = 1'b0;
        still_asleep(3, "R9");
        step(30);
        chk(clk_en == 1'b0, "R9", clk_en, 0);
        hstby_n = 1'b1;
        expect_resume(20, "R10");
        nmi = 1'b0;
        step(10);

        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        end
        $finish;
    end

endmodule